// File: doc/BRIEF.md
# Accumulator ALU with Destination Select

This block is the 8-bit execution unit of a single-accumulator microcontroller core. In each cycle it receives the accumulator value, a file-register operand, an immediate byte, a 5-bit operation code, a destination bit and a bit index. It returns the result byte and a single write strobe, aimed either at the accumulator or back at the file register. It also returns the updated status flags (carry, half carry, zero) and a skip request, which the sequencer uses to discard the next instruction.

The core's decoder drives the operation code. The core's status register feeds the current flags in. Each operation changes only its own set of flags, and the other flags come back out unchanged, so the status register can take `flags_o` every cycle without masking. Subtraction always takes the accumulator away from the other operand. Outputs are registered once by default. Setting the parameter `REG_OUT` to 0 makes the outputs combinational.

Top module: `acc_alu`

## Requirements
- R1: Operations ADD_LIT and ADD_FILE produce W plus the operand, modulo 256. C is the carry out of bit 7, DC is the carry out of bit 3, and Z is set when the result is zero.
- R2: Operations SUB_LIT and SUB_FILE produce the operand minus W in two's complement. C is 1 when no borrow occurs (operand >= W). DC is 1 when the low nibble of the operand is >= the low nibble of W. Z follows the result.
- R3: For every file-form operation, dest_i = 0 raises only wr_w_o and dest_i = 1 raises only wr_f_o. The two write strobes are never high together.
- R4: AND, OR, XOR (literal and file forms), COMP, INC, DEC and MOV_FILE update only Z. MOV_FILE returns the operand unchanged, so with dest_i = 1 it only tests the value.
- R5: CLR_W and CLR_FILE give result 00h and set Z, leaving C and DC as they were. CLR_W writes W and CLR_FILE writes the file register.
- R6: ROT_L gives {operand[6:0], C} with new C = operand[7]. ROT_R gives {C, operand[7:1]} with new C = operand[0]. DC and Z are kept.
- R7: SWAP exchanges operand bits 7:4 with 3:0 and keeps all flags.
- R8: INC_SKZ and DEC_SKZ give the operand plus or minus one, raise skip_o exactly when that result is zero, and keep all flags.
- R9: BIT_SET and BIT_CLR force bit bit_sel_i of the file operand to 1 or 0. They write to the file register, keep all flags and never skip.
- R10: TEST_SET raises skip_o when bit bit_sel_i of the file operand is 1, and TEST_CLR raises it when that bit is 0. Neither writes nor changes a flag.
- R11: MOV_LIT passes the literal to W, and MOV_W2F passes W to the file register. Neither changes a flag.
- R12: Reset clears every output to zero. NOP and the unused codes 28 to 31 give no write and no skip, and pass the flags through.
- R13: With REG_OUT = 1, the outputs reflect the inputs present at the previous rising clock edge. On flags_i and flags_o, bit 0 is C, bit 1 is DC and bit 2 is Z. Operation codes are numbered from 0 in this order: ADD_LIT, ADD_FILE, SUB_LIT, SUB_FILE, AND_LIT, AND_FILE, OR_LIT, OR_FILE, XOR_LIT, XOR_FILE, COMP, INC, DEC, INC_SKZ, DEC_SKZ, MOV_FILE, MOV_LIT, MOV_W2F, CLR_FILE, CLR_W, ROT_L, ROT_R, SWAP, BIT_SET, BIT_CLR, TEST_SET, TEST_CLR, NOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_i | input | 5 | Operation code |
| dest_i | input | 1 | Destination select for file-form operations: 0 = W, 1 = file register |
| bit_sel_i | input | 3 | Bit index for bit set, clear and test |
| w_i | input | 8 | Accumulator value |
| file_i | input | 8 | File-register operand |
| lit_i | input | 8 | Immediate byte |
| flags_i | input | 3 | Current status flags {Z, DC, C} |
| result_o | output | 8 | Result byte |
| wr_w_o | output | 1 | Write strobe toward the accumulator |
| wr_f_o | output | 1 | Write strobe toward the file register |
| flags_o | output | 3 | Updated status flags {Z, DC, C} |
| skip_o | output | 1 | Request to discard the next instruction |

## Verification
The assertions assume that every input is stable around the sampling edge. They also assume that the checker's copy of the operation code and operands lines up with the outputs, one register stage later. The bench meets both assumptions by changing every input only on the falling edge. It also stays in reset until its first driven operation, so that the checker's delayed copy starts as a NOP with zero flags, which matches the reset value of the outputs. The random phase draws codes from the full 5-bit range, including unused values, and draws flags, operands and bit indices freely, because the block places no legality constraint on them.

// File: rtl/acc_alu_pkg.sv
`timescale 1ns/1ps
package acc_alu_pkg;

   typedef enum logic [4:0] {
      OP_ADD_LIT  = 5'd0,
      OP_ADD_FILE = 5'd1,
      OP_SUB_LIT  = 5'd2,
      OP_SUB_FILE = 5'd3,
      OP_AND_LIT  = 5'd4,
      OP_AND_FILE = 5'd5,
      OP_OR_LIT   = 5'd6,
      OP_OR_FILE  = 5'd7,
      OP_XOR_LIT  = 5'd8,
      OP_XOR_FILE = 5'd9,
      OP_COMP     = 5'd10,
      OP_INC      = 5'd11,
      OP_DEC      = 5'd12,
      OP_INC_SKZ  = 5'd13,
      OP_DEC_SKZ  = 5'd14,
      OP_MOV_FILE = 5'd15,
      OP_MOV_LIT  = 5'd16,
      OP_MOV_W2F  = 5'd17,
      OP_CLR_FILE = 5'd18,
      OP_CLR_W    = 5'd19,
      OP_ROT_L    = 5'd20,
      OP_ROT_R    = 5'd21,
      OP_SWAP     = 5'd22,
      OP_BIT_SET  = 5'd23,
      OP_BIT_CLR  = 5'd24,
      OP_TEST_SET = 5'd25,
      OP_TEST_CLR = 5'd26,
      OP_NOP      = 5'd27
   } op_e;

   // Bit 0 = carry, bit 1 = half carry, bit 2 = zero.
   typedef struct packed {
      logic z;
      logic dc;
      logic c;
   } status_t;

   typedef enum logic [1:0] {
      TGT_NONE = 2'd0,
      TGT_W    = 2'd1,
      TGT_FILE = 2'd2,
      TGT_DEST = 2'd3
   } target_e;

   function automatic logic takes_literal(input op_e op);
      return op inside {OP_ADD_LIT, OP_SUB_LIT, OP_AND_LIT, OP_OR_LIT,
                        OP_XOR_LIT, OP_MOV_LIT};
   endfunction

   function automatic target_e target_of(input op_e op);
      case (op)
         OP_ADD_LIT, OP_SUB_LIT, OP_AND_LIT, OP_OR_LIT, OP_XOR_LIT,
         OP_MOV_LIT, OP_CLR_W:                      return TGT_W;
         OP_MOV_W2F, OP_CLR_FILE, OP_BIT_SET,
         OP_BIT_CLR:                                return TGT_FILE;
         OP_ADD_FILE, OP_SUB_FILE, OP_AND_FILE, OP_OR_FILE, OP_XOR_FILE,
         OP_COMP, OP_INC, OP_DEC, OP_INC_SKZ, OP_DEC_SKZ, OP_MOV_FILE,
         OP_ROT_L, OP_ROT_R, OP_SWAP:               return TGT_DEST;
         default:                                   return TGT_NONE;
      endcase
   endfunction

endpackage

// File: rtl/acc_alu_arith.sv
`timescale 1ns/1ps
// Shared adder: operand + W, or operand + ~W + 1 for subtraction.
module acc_alu_arith #(
   parameter int WIDTH = 8
) (
   input  logic [WIDTH-1:0] opnd,
   input  logic [WIDTH-1:0] acc,
   input  logic             sub,
   output logic [WIDTH-1:0] sum,
   output logic             carry,
   output logic             half_carry
);
   localparam int HALF = WIDTH / 2;

   logic [WIDTH-1:0] addend;
   logic [WIDTH:0]   full;
   logic [HALF:0]    low;

   always_comb begin
      addend     = sub ? ~acc : acc;
      full       = {1'b0, opnd} + {1'b0, addend} + {{WIDTH{1'b0}}, sub};
      low        = {1'b0, opnd[HALF-1:0]} + {1'b0, addend[HALF-1:0]}
                 + {{HALF{1'b0}}, sub};
      sum        = full[WIDTH-1:0];
      carry      = full[WIDTH];
      half_carry = low[HALF];
   end
endmodule

// File: rtl/acc_alu_unary.sv
`timescale 1ns/1ps
// Logic, step, rotate, swap and bit-field operations.
module acc_alu_unary
   import acc_alu_pkg::*;
#(
   parameter int WIDTH = 8,
   parameter int BIT_W = 3
) (
   input  op_e              op,
   input  logic [WIDTH-1:0] opnd,
   input  logic [WIDTH-1:0] acc,
   input  logic [BIT_W-1:0] bit_sel,
   input  logic             c_in,
   output logic [WIDTH-1:0] res,
   output logic             c_out,
   output logic             bit_val
);
   localparam int HALF = WIDTH / 2;

   logic [WIDTH-1:0] mask;

   for (genvar i = 0; i < WIDTH; i++) begin : g_mask
      assign mask[i] = (bit_sel == BIT_W'(i));
   end

   assign bit_val = |(opnd & mask);

   always_comb begin
      c_out = c_in;
      case (op)
         OP_AND_LIT, OP_AND_FILE: res = acc & opnd;
         OP_OR_LIT,  OP_OR_FILE:  res = acc | opnd;
         OP_XOR_LIT, OP_XOR_FILE: res = acc ^ opnd;
         OP_COMP:                 res = ~opnd;
         OP_INC, OP_INC_SKZ:      res = opnd + WIDTH'(1);
         OP_DEC, OP_DEC_SKZ:      res = opnd - WIDTH'(1);
         OP_MOV_W2F:              res = acc;
         OP_CLR_FILE, OP_CLR_W:   res = '0;
         OP_ROT_L: begin
            res   = {opnd[WIDTH-2:0], c_in};
            c_out = opnd[WIDTH-1];
         end
         OP_ROT_R: begin
            res   = {c_in, opnd[WIDTH-1:1]};
            c_out = opnd[0];
         end
         OP_SWAP:                 res = {opnd[HALF-1:0], opnd[WIDTH-1:HALF]};
         OP_BIT_SET:              res = opnd | mask;
         OP_BIT_CLR:              res = opnd & ~mask;
         default:                 res = opnd;
      endcase
   end
endmodule

// File: rtl/acc_alu_route.sv
`timescale 1ns/1ps
// Result pick, write target, flag update mask and skip decision.
module acc_alu_route
   import acc_alu_pkg::*;
#(
   parameter int WIDTH = 8
) (
   input  op_e              op,
   input  logic             dest,
   input  logic [WIDTH-1:0] arith_sum,
   input  logic             arith_c,
   input  logic             arith_dc,
   input  logic [WIDTH-1:0] unary_res,
   input  logic             unary_c,
   input  logic             bit_val,
   input  status_t          fl_in,
   output logic [WIDTH-1:0] res,
   output logic             wr_w,
   output logic             wr_f,
   output status_t          fl_out,
   output logic             skip
);
   logic    upd_c, upd_dc, upd_z, new_c, new_dc, is_zero;
   target_e tgt;

   always_comb begin
      upd_c  = 1'b0;
      upd_dc = 1'b0;
      upd_z  = 1'b0;
      new_c  = unary_c;
      new_dc = fl_in.dc;
      skip   = 1'b0;
      res    = unary_res;
      case (op)
         OP_ADD_LIT, OP_ADD_FILE, OP_SUB_LIT, OP_SUB_FILE: begin
            res    = arith_sum;
            new_c  = arith_c;
            new_dc = arith_dc;
            upd_c  = 1'b1;
            upd_dc = 1'b1;
            upd_z  = 1'b1;
         end
         OP_AND_LIT, OP_AND_FILE, OP_OR_LIT, OP_OR_FILE, OP_XOR_LIT,
         OP_XOR_FILE, OP_COMP, OP_INC, OP_DEC, OP_MOV_FILE,
         OP_CLR_FILE, OP_CLR_W:  upd_z = 1'b1;
         OP_ROT_L, OP_ROT_R:     upd_c = 1'b1;
         OP_INC_SKZ, OP_DEC_SKZ: skip  = (unary_res == '0);
         OP_TEST_SET:            skip  = bit_val;
         OP_TEST_CLR:            skip  = ~bit_val;
         default: ;
      endcase

      is_zero   = (res == '0);
      fl_out.c  = upd_c  ? new_c   : fl_in.c;
      fl_out.dc = upd_dc ? new_dc  : fl_in.dc;
      fl_out.z  = upd_z  ? is_zero : fl_in.z;

      tgt  = target_of(op);
      wr_w = (tgt == TGT_W)    || ((tgt == TGT_DEST) && !dest);
      wr_f = (tgt == TGT_FILE) || ((tgt == TGT_DEST) &&  dest);
   end
endmodule

// File: rtl/acc_alu.sv
`timescale 1ns/1ps
module acc_alu
   import acc_alu_pkg::*;
#(
   parameter int WIDTH   = 8,
   parameter int BIT_W   = 3,
   parameter bit REG_OUT = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [4:0]       op_i,
   input  logic             dest_i,
   input  logic [BIT_W-1:0] bit_sel_i,
   input  logic [WIDTH-1:0] w_i,
   input  logic [WIDTH-1:0] file_i,
   input  logic [WIDTH-1:0] lit_i,
   input  logic [2:0]       flags_i,
   output logic [WIDTH-1:0] result_o,
   output logic             wr_w_o,
   output logic             wr_f_o,
   output logic [2:0]       flags_o,
   output logic             skip_o
);
   localparam int HALF = WIDTH / 2;

   if (WIDTH < 4 || (WIDTH % 2) != 0) begin : g_bad_width
      $error("acc_alu: WIDTH must be even and at least 4");
   end
   if (BIT_W != $clog2(WIDTH)) begin : g_bad_bitw
      $error("acc_alu: BIT_W must equal clog2(WIDTH)");
   end
   if (HALF * 2 != WIDTH) begin : g_bad_half
      $error("acc_alu: nibble split needs an even width");
   end

   op_e              op;
   status_t          fl_in, fl_nx;
   logic [WIDTH-1:0] opnd, a_sum, u_res, r_nx;
   logic             a_c, a_dc, u_c, b_val, ww_nx, wf_nx, sk_nx, is_sub;

   assign op     = op_e'(op_i);
   assign fl_in  = flags_i;
   assign opnd   = takes_literal(op) ? lit_i : file_i;
   assign is_sub = (op == OP_SUB_LIT) || (op == OP_SUB_FILE);

   acc_alu_arith #(.WIDTH(WIDTH)) u_arith (
      .opnd       (opnd),
      .acc        (w_i),
      .sub        (is_sub),
      .sum        (a_sum),
      .carry      (a_c),
      .half_carry (a_dc)
   );

   acc_alu_unary #(.WIDTH(WIDTH), .BIT_W(BIT_W)) u_unary (
      .op      (op),
      .opnd    (opnd),
      .acc     (w_i),
      .bit_sel (bit_sel_i),
      .c_in    (fl_in.c),
      .res     (u_res),
      .c_out   (u_c),
      .bit_val (b_val)
   );

   acc_alu_route #(.WIDTH(WIDTH)) u_route (
      .op        (op),
      .dest      (dest_i),
      .arith_sum (a_sum),
      .arith_c   (a_c),
      .arith_dc  (a_dc),
      .unary_res (u_res),
      .unary_c   (u_c),
      .bit_val   (b_val),
      .fl_in     (fl_in),
      .res       (r_nx),
      .wr_w      (ww_nx),
      .wr_f      (wf_nx),
      .fl_out    (fl_nx),
      .skip      (sk_nx)
   );

   if (REG_OUT) begin : g_reg
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            result_o <= '0;
            wr_w_o   <= 1'b0;
            wr_f_o   <= 1'b0;
            flags_o  <= '0;
            skip_o   <= 1'b0;
         end else begin
            result_o <= r_nx;
            wr_w_o   <= ww_nx;
            wr_f_o   <= wf_nx;
            flags_o  <= fl_nx;
            skip_o   <= sk_nx;
         end
      end
   end else begin : g_comb
      assign result_o = r_nx;
      assign wr_w_o   = ww_nx;
      assign wr_f_o   = wf_nx;
      assign flags_o  = fl_nx;
      assign skip_o   = sk_nx;
   end
endmodule

// File: rtl/acc_alu_chk.sv
`timescale 1ns/1ps
module acc_alu_chk
   import acc_alu_pkg::*;
#(
   parameter int WIDTH   = 8,
   parameter bit REG_OUT = 1'b1
) (
   input logic             clk,
   input logic             rst_n,
   input logic [4:0]       op_i,
   input logic [WIDTH-1:0] w_i,
   input logic [WIDTH-1:0] lit_i,
   input logic [2:0]       flags_i,
   input logic [WIDTH-1:0] result_o,
   input logic             wr_w_o,
   input logic             wr_f_o,
   input logic [2:0]       flags_o,
   input logic             skip_o
);
   op_e              op_d;
   logic [WIDTH-1:0] w_d, lit_d;
   logic [2:0]       fl_d;

   if (REG_OUT) begin : g_dly
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            op_d  <= OP_NOP;
            w_d   <= '0;
            lit_d <= '0;
            fl_d  <= '0;
         end else begin
            op_d  <= op_e'(op_i);
            w_d   <= w_i;
            lit_d <= lit_i;
            fl_d  <= flags_i;
         end
      end
   end else begin : g_dir
      assign op_d  = op_e'(op_i);
      assign w_d   = w_i;
      assign lit_d = lit_i;
      assign fl_d  = flags_i;
   end

   AST_SINGLE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_w_o && wr_f_o)); // R3

   AST_ADD_LIT_SUM: assert property (@(posedge clk) disable iff (!rst_n)
      (op_d == OP_ADD_LIT) |-> (result_o == WIDTH'(w_d + lit_d)) && wr_w_o); // R1

   AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (op_d inside {OP_CLR_W, OP_CLR_FILE}) |->
         (result_o == '0) && flags_o[2] && (flags_o[1:0] == fl_d[1:0])); // R5

   AST_SWAP_KEEPS_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
      (op_d == OP_SWAP) |-> (flags_o == fl_d)); // R7

   AST_SKZ_FLAGS_SKIP: assert property (@(posedge clk) disable iff (!rst_n)
      (op_d inside {OP_INC_SKZ, OP_DEC_SKZ}) |->
         (flags_o == fl_d) && (skip_o == (result_o == '0))); // R8

   AST_TEST_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (op_d inside {OP_TEST_SET, OP_TEST_CLR}) |->
         !wr_w_o && !wr_f_o && (flags_o == fl_d)); // R10

   AST_SKIP_SOURCES: assert property (@(posedge clk) disable iff (!rst_n)
      skip_o |-> (op_d inside {OP_INC_SKZ, OP_DEC_SKZ, OP_TEST_SET, OP_TEST_CLR})); // R12

   AST_MOVLIT_PASS: assert property (@(posedge clk) disable iff (!rst_n)
      (op_d == OP_MOV_LIT) |-> (result_o == lit_d) && (flags_o == fl_d)); // R11
endmodule

bind acc_alu acc_alu_chk #(.WIDTH(WIDTH), .REG_OUT(REG_OUT)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .op_i     (op_i),
   .w_i      (w_i),
   .lit_i    (lit_i),
   .flags_i  (flags_i),
   .result_o (result_o),
   .wr_w_o   (wr_w_o),
   .wr_f_o   (wr_f_o),
   .flags_o  (flags_o),
   .skip_o   (skip_o)
);

// File: tb/acc_alu_test.sv
`timescale 1ns/1ps
module acc_alu_test;
   import acc_alu_pkg::*;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [4:0] op_i = 5'd27;
   logic       dest_i = 1'b0;
   logic [2:0] bit_sel_i = '0;
   logic [7:0] w_i = '0, file_i = '0, lit_i = '0;
   logic [2:0] flags_i = '0;
   logic [7:0] result_o;
   logic       wr_w_o, wr_f_o, skip_o;
   logic [2:0] flags_o;

   int checks = 0;
   int errors = 0;

   always #4 clk = ~clk;

   acc_alu uut (
      .clk(clk), .rst_n(rst_n), .op_i(op_i), .dest_i(dest_i),
      .bit_sel_i(bit_sel_i), .w_i(w_i), .file_i(file_i), .lit_i(lit_i),
      .flags_i(flags_i), .result_o(result_o), .wr_w_o(wr_w_o),
      .wr_f_o(wr_f_o), .flags_o(flags_o), .skip_o(skip_o)
   );

   // Packed {result[7:0], wr_w, wr_f, flags[2:0], skip}
   function automatic logic [13:0] model(int op, int d, int b, int w,
                                         int f, int l, int fl);
      int c = fl & 1, dc = (fl >> 1) & 1, z = (fl >> 2) & 1;
      int ww = 0, wf = 0, sk = 0, r = 0, x = f;
      int route = 0; // 1 = destination bit decides
      if (op inside {0, 2, 4, 6, 8, 16}) x = l;
      case (op)
         0, 1:   begin r = w + x; c = (r > 255) ? 1 : 0;
                       dc = ((w % 16) + (x % 16) > 15) ? 1 : 0;
                       r = r % 256; z = (r == 0); end
         2, 3:   begin c = (x >= w) ? 1 : 0; dc = ((x % 16) >= (w % 16)) ? 1 : 0;
                       r = (x - w + 256) % 256; z = (r == 0); end
         4, 5:   begin r = w & x; z = (r == 0); end
         6, 7:   begin r = w | x; z = (r == 0); end
         8, 9:   begin r = w ^ x; z = (r == 0); end
         10:     begin r = 255 - x; z = (r == 0); end
         11:     begin r = (x + 1) % 256; z = (r == 0); end
         12:     begin r = (x + 255) % 256; z = (r == 0); end
         13:     begin r = (x + 1) % 256; sk = (r == 0); end
         14:     begin r = (x + 255) % 256; sk = (r == 0); end
         15:     begin r = x; z = (r == 0); end
         16:     r = x;
         17:     r = w;
         18, 19: begin r = 0; z = 1; end
         20:     begin r = ((x * 2) % 256) + c; c = x / 128; end
         21:     begin r = (x / 2) + c * 128; c = x % 2; end
         22:     r = (x % 16) * 16 + x / 16;
         23:     r = x | (1 << b);
         24:     r = x & (255 - (1 << b));
         25:     begin r = x; sk = (x >> b) & 1; end
         26:     begin r = x; sk = 1 - ((x >> b) & 1); end
         default: r = x;
      endcase
      if (op inside {0, 2, 4, 6, 8, 16, 19}) ww = 1;
      if (op inside {17, 18, 23, 24}) wf = 1;
      if (op inside {1, 3, 5, 7, 9, 10, 11, 12, 13, 14, 15, 20, 21, 22}) route = 1;
      if (route == 1) begin ww = (d == 0); wf = (d != 0); end
      return {r[7:0], ww[0], wf[0], z[0], dc[0], c[0], sk[0]};
   endfunction

   function automatic string tag_of(int op);
      if (op inside {0, 1}) return "R1";
      if (op inside {2, 3}) return "R2";
      if (op inside {4, 5, 6, 7, 8, 9, 10, 11, 12, 15}) return "R4";
      if (op inside {18, 19}) return "R5";
      if (op inside {20, 21}) return "R6";
      if (op == 22) return "R7";
      if (op inside {13, 14}) return "R8";
      if (op inside {23, 24}) return "R9";
      if (op inside {25, 26}) return "R10";
      if (op inside {16, 17}) return "R11";
      return "R12";
   endfunction

   task automatic compare(string tag, logic [13:0] exp);
      logic [13:0] act;
      act = {result_o, wr_w_o, wr_f_o, flags_o, skip_o};
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual res=%h ww=%b wf=%b fl=%b sk=%b expected res=%h ww=%b wf=%b fl=%b sk=%b",
                  tag, act[13:6], act[5], act[4], act[3:1], act[0],
                  exp[13:6], exp[5], exp[4], exp[3:1], exp[0]);
      end
   endtask

   // Driven just after a falling edge; result sampled one clock later, mid-low phase.
   task automatic run(string tag, int op, int d, int b, int w, int f, int l, int fl);
      logic [13:0] exp;
      op_i = op[4:0]; dest_i = d[0]; bit_sel_i = b[2:0];
      w_i = w[7:0]; file_i = f[7:0]; lit_i = l[7:0]; flags_i = fl[2:0];
      exp = model(op, d, b, w, f, l, fl);
      @(posedge clk);
      @(negedge clk);
      compare(tag, exp);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      compare("R12 reset", 14'd0);
      rst_n = 1'b1;
      // R13: bit 0 of flags is C, bit 2 is Z; one-cycle latency
      run("R1 half carry",   0, 0, 0, 8'h0F, 0, 8'h01, 0);
      run("R1 full carry",   1, 1, 0, 8'hFF, 8'h01, 0, 0);
      run("R13 add flags",   1, 0, 0, 8'h80, 8'h80, 0, 3'b010);
      run("R2 equal",        2, 0, 0, 8'h05, 0, 8'h05, 0);
      run("R2 borrow",       3, 1, 0, 8'h05, 8'h03, 0, 3'b111);
      run("R2 half borrow",  3, 0, 0, 8'h01, 8'h10, 0, 0);
      run("R3 dest w",       5, 0, 0, 8'hF0, 8'h3C, 0, 0);
      run("R3 dest file",    5, 1, 0, 8'hF0, 8'h3C, 0, 0);
      run("R4 move test",   15, 1, 0, 0, 8'h00, 0, 3'b011);
      run("R4 complement",  10, 0, 0, 0, 8'hFF, 0, 3'b011);
      run("R5 clear w",     19, 0, 0, 8'h55, 0, 0, 3'b011);
      run("R5 clear file",  18, 0, 0, 0, 8'h77, 0, 3'b000);
      run("R6 rotate left", 20, 1, 0, 0, 8'h80, 0, 3'b001);
      run("R6 rotate right",21, 0, 0, 0, 8'h01, 0, 3'b000);
      run("R7 swap",        22, 1, 0, 0, 8'hA5, 0, 3'b101);
      run("R8 dec to zero", 14, 1, 0, 0, 8'h01, 0, 3'b010);
      run("R8 inc wrap",    13, 0, 0, 0, 8'hFF, 0, 3'b000);
      run("R8 no skip",     14, 0, 0, 0, 8'h05, 0, 3'b000);
      run("R9 set bit7",    23, 0, 7, 0, 8'h00, 0, 3'b100);
      run("R9 clear bit0",  24, 1, 0, 0, 8'hFF, 0, 3'b001);
      run("R10 test set",   25, 0, 3, 0, 8'h08, 0, 3'b000);
      run("R10 test clr",   26, 0, 3, 0, 8'h08, 0, 3'b000);
      run("R10 test clr hit",26,1, 6, 0, 8'h08, 0, 3'b110);
      run("R11 move lit",   16, 1, 0, 8'h11, 8'h22, 8'h00, 3'b011);
      run("R11 w to file",  17, 0, 0, 8'h9C, 8'h22, 0, 3'b000);
      run("R12 nop",        27, 1, 0, 8'h11, 8'h22, 8'h33, 3'b101);
      run("R12 unused",     30, 1, 0, 8'h11, 8'h22, 8'h33, 3'b110);
      for (int i = 0; i < 800; i++) begin
         int op;
         op = $urandom_range(0, 31);
         run(tag_of(op), op, $urandom_range(0, 1), $urandom_range(0, 7),
             $urandom_range(0, 255), $urandom_range(0, 255),
             $urandom_range(0, 255), $urandom_range(0, 7));
      end
      rst_n = 1'b0;
      @(posedge clk);
      @(negedge clk);
      compare("R12 reset again", 14'd0);
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule